// File: doc/BRIEF.md
# Daisy-Chained Priority Bus Arbiter

This block grants ownership of a shared bus to one of several requesting devices. Devices are grouped into priority levels. On each level the individual requests merge into one level request, and the central selector answers with a single grant pulse for that level. The pulse enters a pass-through chain at device 0. A device that is requesting when the pulse reaches it keeps it. A device that is not requesting passes it along to the next one. Chain position therefore decides the winner within a level, and the selector decides which level is served.

A device that captures the grant becomes the bus owner. A shared busy flag stays high for as long as any device owns the bus. While busy is high the selector offers no grant. The owner keeps the bus until it withdraws its request, and a newly arriving higher-priority request does not preempt it. Outputs are a one-hot per-device grant vector, the owner's flat index and the busy flag. The per-level grant pulses are also exposed.

Top module: `daisy_bus_arbiter`

## Requirements
- R1: A level counts as pending when any one of its devices requests. Device d of level l is on req_i bit l*DEVS+d.
- R2: Level 0 has the highest priority. At a clock edge where busy_o is low, no level grant is outstanding and some level is pending, the selector raises exactly one bit of lvl_gnt_o, bit l for the highest-priority pending level. That bit is high for exactly one cycle.
- R3: Within the granted level, the lowest-index requesting device captures the grant at the next edge. gnt_o then has bit l*DEVS+d set.
- R4: Non-requesting devices pass the grant on. If no device on the level still requests when the pulse arrives, nobody captures it, and gnt_o and busy_o stay low.
- R5: At most one bit of gnt_o is set at any time.
- R6: busy_o is high exactly when some device holds its grant. It rises at the edge where the grant is captured, which is the cycle after the level grant pulse.
- R7: No level grant is issued while busy_o is high.
- R8: The owner keeps its grant while its request stays high, even when requests with higher priority arrive.
- R9: The edge where the owner drops its request clears gnt_o and busy_o. A pending request receives a level grant at the following edge.
- R10: owner_o gives the flat index of the set gnt_o bit, and reads 0 when no device owns the bus.
- R11: While rst_ni is low, gnt_o, lvl_gnt_o, busy_o and owner_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | LEVELS*DEVS | Per-device request, index l*DEVS+d |
| gnt_o | output | LEVELS*DEVS | One-hot per-device held grant |
| lvl_gnt_o | output | LEVELS | Per-level grant pulse entering each chain |
| busy_o | output | 1 | Bus owned by some device |
| owner_o | output | IDX_W | Flat index of the current owner |

## Verification
The assertions check on every cycle that at most one device and at most one level hold a grant, that no level grant appears while the bus is busy, that a level grant lasts only one cycle and never skips a pending level of higher priority, and that an owner holds its grant while it requests and drops it when it stops. Only the bench scenarios can show which device actually wins. The bench sweeps every request pattern of the default configuration. It also shows that a request withdrawn before the grant arrives leaves the bus idle, and that a higher-priority request waits for the owner to release before it is served.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
  typedef enum logic {
    SEL_IDLE  = 1'b0,  // may offer a grant
    SEL_OFFER = 1'b1   // grant pulse on a level line
  } sel_state_e;
endpackage

// File: rtl/dcb_chain_cell.sv
module dcb_chain_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_in_i,
  input  logic req_i,
  output logic gnt_out_o,
  output logic own_o
);
  logic own_q, own_d, take;

  assign take      = gnt_in_i & req_i;
  assign gnt_out_o = gnt_in_i & ~req_i & ~own_q;
  assign own_d     = own_q ? req_i : take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= 1'b0;
    else         own_q <= own_d;
  end

  assign own_o = own_q;

  // R8
  owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q && req_i) |=> own_q);
  // R9
  owner_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_q && !req_i) |=> !own_q);
  // R3
  capture_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!own_q && !(gnt_in_i && req_i)) |=> !own_q);
endmodule

// File: rtl/dcb_level_chain.sv
module dcb_level_chain #(
  parameter int unsigned DEVS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lvl_gnt_i,
  input  logic [DEVS-1:0] req_i,
  output logic            lvl_req_o,
  output logic [DEVS-1:0] own_o
);
  logic [DEVS:0] gnt_w;

  assign gnt_w[0]  = lvl_gnt_i;
  assign lvl_req_o = |req_i;  // wired-OR equivalent

  for (genvar d = 0; d < DEVS; d++) begin : g_cell
    dcb_chain_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .gnt_in_i  (gnt_w[d]),
      .req_i     (req_i[d]),
      .gnt_out_o (gnt_w[d+1]),
      .own_o     (own_o[d])
    );
  end

  // R4
  tail_only_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_w[DEVS] |-> (req_i == '0));
  // R5
  chain_single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own_o));
endmodule

// File: rtl/dcb_level_select.sv
module dcb_level_select
  import daisy_arb_pkg::*;
#(
  parameter int unsigned LEVELS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEVELS-1:0] lvl_req_i,
  input  logic              busy_i,
  output logic [LEVELS-1:0] lvl_gnt_o
);
  sel_state_e        state_q, state_d;
  logic [LEVELS-1:0] pick, gnt_q, gnt_d;

  // lowest index wins: highest priority
  always_comb begin
    pick = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (lvl_req_i[l]) pick = LEVELS'(1) << l;
    end
  end

  always_comb begin
    state_d = SEL_IDLE;
    gnt_d   = '0;
    if (state_q == SEL_IDLE && !busy_i && (lvl_req_i != '0)) begin
      state_d = SEL_OFFER;
      gnt_d   = pick;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEL_IDLE;
      gnt_q   <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
    end
  end

  assign lvl_gnt_o = gnt_q;

  // R2
  lvl_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  // R2
  lvl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q != '0) |=> (gnt_q == '0));
  // R2
  lvl_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_q != '0) |-> ((($past(lvl_req_i) & (gnt_q - LEVELS'(1))) == '0)
                       && (($past(lvl_req_i) & gnt_q) != '0)));
  // R7
  no_grant_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (gnt_q == '0));
endmodule

// File: rtl/daisy_bus_arbiter.sv
module daisy_bus_arbiter #(
  parameter int unsigned LEVELS = 2,
  parameter int unsigned DEVS   = 4,
  localparam int unsigned N     = LEVELS * DEVS,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_i,
  output logic [N-1:0]      gnt_o,
  output logic [LEVELS-1:0] lvl_gnt_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  owner_o
);
  logic [LEVELS-1:0] lvl_req, lvl_gnt;
  logic [N-1:0]      own;
  logic              busy;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    dcb_level_chain #(.DEVS(DEVS)) u_chain (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_gnt_i (lvl_gnt[l]),
      .req_i     (req_i[l*DEVS +: DEVS]),
      .lvl_req_o (lvl_req[l]),
      .own_o     (own[l*DEVS +: DEVS])
    );
  end

  assign busy = |own;

  dcb_level_select #(.LEVELS(LEVELS)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_req_i (lvl_req),
    .busy_i    (busy),
    .lvl_gnt_o (lvl_gnt)
  );

  always_comb begin
    owner_o = '0;
    for (int i = 0; i < N; i++) begin
      if (own[i]) owner_o = IDX_W'(i);
    end
  end

  assign gnt_o     = own;
  assign lvl_gnt_o = lvl_gnt;
  assign busy_o    = busy;

  // R5
  single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R6
  capture_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(lvl_gnt_o) != '0));
  // R10
  owner_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> gnt_o[owner_o]);
endmodule

// File: tb/daisy_bus_arbiter_tb.sv
`timescale 1ns/1ps
module daisy_bus_arbiter_tb;
  localparam int LEVELS = 2;
  localparam int DEVS   = 4;
  localparam int N      = LEVELS * DEVS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  gnt;
  logic [LEVELS-1:0] lvl_gnt;
  logic          busy;
  logic [2:0]    owner;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  daisy_bus_arbiter #(.LEVELS(LEVELS), .DEVS(DEVS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .gnt_o(gnt), .lvl_gnt_o(lvl_gnt), .busy_o(busy), .owner_o(owner)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int low_bit(int p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w;
    // R11 reset state
    @(negedge clk); req = 8'hFF; @(negedge clk);
    chk("R11 gnt", gnt, 0); chk("R11 lvl", lvl_gnt, 0);
    chk("R11 busy", busy, 0); chk("R11 owner", owner, 0);
    req = '0;
    @(negedge clk); rst_n = 1'b1; step();

    // R1 R2 R3 R5 R6 R7 R8 R9 R10: sweep of every request pattern
    for (int p = 0; p < (1 << N); p++) begin
      w = low_bit(p);
      req = N'(p);
      step();
      chk("R1/R2 lvl pulse", lvl_gnt, (p != 0) ? (1 << (w / DEVS)) : 0);
      chk("R6 no early grant", gnt, 0);
      step();
      chk("R3 winner", gnt, (p != 0) ? (1 << w) : 0);
      chk("R6 busy", busy, (p != 0) ? 1 : 0);
      chk("R10 owner", owner, (p != 0) ? w : 0);
      chk("R2 pulse ends", lvl_gnt, 0);
      step();
      chk("R8 hold", gnt, (p != 0) ? (1 << w) : 0);
      chk("R7 no grant while busy", lvl_gnt, 0);
      req = '0;
      step();
      chk("R9 release gnt", gnt, 0);
      chk("R9 release busy", busy, 0);
      chk("R10 idle owner", owner, 0);
      step();
    end

    // R4: requester withdraws before pulse arrives
    req = 8'h20; step();
    chk("R4 pulse level1", lvl_gnt, 2);
    req = '0; step();
    chk("R4 nobody captures", gnt, 0);
    chk("R4 not busy", busy, 0);
    step();

    // R4: non-requester passes grant along level 1
    req = 8'h40; step(); step();
    chk("R4 passed to dev6", gnt, 8'h40);
    req = '0; step(); step();

    // R8 no preemption, R9 handover
    req = 8'h20; step(); step();
    chk("R8 level1 owner", gnt, 8'h20);
    req = 8'h21; step();
    chk("R8 no preempt lvl", lvl_gnt, 0);
    step();
    chk("R8 no preempt gnt", gnt, 8'h20);
    req = 8'h01; step();
    chk("R9 released", busy, 0);
    chk("R9 no pulse yet", lvl_gnt, 0);
    step();
    chk("R9 new pulse", lvl_gnt, 1);
    step();
    chk("R9 new owner", gnt, 8'h01);
    chk("R10 new owner idx", owner, 0);
    req = '0; step(); step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule